// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block turns single-word read and write requests into SDR SDRAM command sequences. A request carries a flat word address, a direction flag, write data and byte enables. The sequencer splits the address into row, bank and column fields. It drives ACTIVE, waits the row-to-column delay, and then issues READ or WRITE. After that it issues PRECHARGE, and only then does it take the next request. Every timing limit is a parameter counted in clock cycles. The defaults suit a 10 ns clock on the fastest device grade. Read data is captured after a CAS latency of 2 or 3 cycles, chosen at run time for each request.

The request side is a valid/ready stream. The host holds `req_valid` and its fields stable until it sees `req_ready` high on a rising edge. The sequencer lowers `req_ready` from the edge that accepts a request until the row has been closed and every recovery limit has passed. It also lowers `req_ready` for as long as `refresh_busy` is high, because the refresh logic owns the pins in that time. The read return path cannot apply back-pressure, because the memory does not wait. `rd_valid` is a one-cycle pulse, and the consumer has to take `rd_data` in that cycle. Commands go out on separate strobes. The data bus is split into an output, an output enable and an input.

The block uses a close-page policy. Each access opens its row and closes it again, so no row ever stays open near the maximum active time.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, the command pins show NOP, `rd_valid` is low, `sd_dq_oe` is low, and `req_ready` is high unless `refresh_busy` is high.
- R2: The request address splits as column = bits 8..0, bank = bits 10..9 and row = bits 22..11. The row goes out on `sd_a` with ACTIVE. The column goes out on `sd_a[8:0]` with READ or WRITE, with `sd_a[10]` low (no auto-precharge). The bank goes out on `sd_ba` with both commands.
- R3: The pins {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} carry ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010 and NOP=0111. Every cycle that holds no scheduled command is NOP.
- R4: ACTIVE occurs in the cycle after the accepting edge. The READ or WRITE follows exactly T_RCD cycles after ACTIVE (default 2).
- R5: PRECHARGE, with `sd_a[10]` high for all banks, comes max(T_RAS, T_RCD+1) cycles after ACTIVE for a read. For a write it comes max(T_RAS, T_RCD+T_WR) cycles after ACTIVE. The default is 5 in both cases. A row is never open for T_RAS_MAX cycles or longer.
- R6: The next ACTIVE is no earlier than PRECHARGE+T_RP and no earlier than ACTIVE+T_RC. After a write it is also no earlier than WRITE+T_DAL. `req_ready` rises one cycle before that earliest point, so requests held back to back produce ACTIVE every 7 cycles by default.
- R7: `req_ready` is low from the accepting edge until the sequence ends, and also whenever `refresh_busy` is high. A request that is valid while `req_ready` is low issues no command.
- R8: In the WRITE cycle only, `sd_dq_oe` is high and `sd_dq_out` carries the write data. In that cycle `sd_dqm[i]` is the inverse of `req_be[i]`, so a low enable masks byte i. In all other cycles `sd_dq_oe` and `sd_dqm` are 0.
- R9: `cas_lat3` is sampled when a request is accepted (1 = latency 3, 0 = latency 2). `sd_dq_in` is captured on the edge that is CL edges after the edge registering READ. The captured word appears on `rd_data`, with `rd_valid` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | CAS latency select, sampled on accept: 1 = 3, 0 = 2 |
| refresh_busy | input | 1 | Refresh logic owns the pins; holds off new requests |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on an edge where valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Flat word address {row, bank, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables, bit i covers byte i |
| rd_valid | output | 1 | One-cycle pulse with returned read data |
| rd_data | output | 32 | Returned read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column address; bit 10 selects all banks on PRECHARGE |
| sd_dqm | output | 4 | Data mask, one bit per byte |
| sd_dq_out | output | 32 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 32 | Data returned by the memory |

## Verification
The embedded assertions check the spacing rules on every cycle:
- ACTIVE to the column command, and PRECHARGE against both row-active time and write recovery.
- ACTIVE to ACTIVE against row cycle, precharge time and data-in-to-active.
- The upper bound on how long a row stays open.
- That the data bus is driven only on WRITE.
- That each read result arrives exactly CL+1 cycles after its READ.

Only the bench scenarios can show that the right address fields reach the right pins and that masked bytes survive. They also show that a latency change between requests moves the capture point, and that requests held during refresh or a busy sequence leave the pins quiet.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_COL,
    ST_HOLD,
    ST_PRE,
    ST_RECOV
  } seq_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_addr_split.sv
module sdram_seq_addr_split #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  // column in the low bits, bank above it, row on top
  assign col  = addr[COL_W-1:0];
  assign bank = addr[COL_W +: BANK_W];
  assign row  = addr[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/sdram_seq_age.sv
module sdram_seq_age #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  // cycles since the last restart, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '1;
    else if (restart)     age <= '0;
    else if (age != '1)   age <= age + 1'b1;
  end
endmodule

// File: rtl/sdram_seq_rd_capture.sv
module sdram_seq_rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              cl3,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  // slot[k] high on the edge k+1 after the READ edge
  logic [2:0] slot;
  logic [2:0] slot_cl3;
  logic       take2, take3;

  assign take2 = slot[1] & ~slot_cl3[1];
  assign take3 = slot[2] &  slot_cl3[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= '0;
      slot_cl3 <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      slot     <= {slot[1:0], issue};
      slot_cl3 <= {slot_cl3[1:0], cl3};
      rd_valid <= take2 | take3;
      if (take2 | take3) rd_data <= dq_in;
    end
  end

  // R9
  one_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take2, take3}));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_WR      = 2,
  parameter int T_DAL     = 5,
  parameter int T_RAS_MAX = 10000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cas_lat3,
  input  logic                          refresh_busy,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_a,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int BE_W   = DATA_W / 8;
  // age (cycles after ACTIVE) of PRECHARGE and of the next ACTIVE
  localparam int P_RD   = max2(T_RAS, T_RCD + 1);
  localparam int P_WR   = max2(T_RAS, T_RCD + T_WR);
  localparam int N_RD   = max2(P_RD + T_RP, T_RC);
  localparam int N_WR   = max2(max2(P_WR + T_RP, T_RC), T_RCD + T_DAL);
  localparam int AGE_W  = $clog2(max2(N_RD, N_WR) + 2) + 1;
  localparam int CHK_W  = 16;

  seq_st_e            st, st_nx;
  sd_cmd_e            cmd;
  logic               accept;
  logic [AGE_W-1:0]   age;
  int                 age_n;

  logic [ROW_W-1:0]   a_row;
  logic [BANK_W-1:0]  a_bank;
  logic [COL_W-1:0]   a_col;

  logic               q_wr, q_cl3;
  logic [ROW_W-1:0]   q_row;
  logic [BANK_W-1:0]  q_bank;
  logic [COL_W-1:0]   q_col;
  logic [DATA_W-1:0]  q_wdata;
  logic [BE_W-1:0]    q_be;

  sdram_seq_addr_split #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
  ) split_i (
    .addr(req_addr), .row(a_row), .bank(a_bank), .col(a_col)
  );

  sdram_seq_age #(.W(AGE_W)) age_i (
    .clk(clk), .rst_n(rst_n), .restart(accept), .age(age)
  );

  assign req_ready = (st == ST_IDLE) && !refresh_busy;
  assign accept    = req_valid && req_ready;
  assign age_n     = int'(age) + 1;

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wr    <= 1'b0;
      q_cl3   <= 1'b0;
      q_row   <= '0;
      q_bank  <= '0;
      q_col   <= '0;
      q_wdata <= '0;
      q_be    <= '0;
    end else if (accept) begin
      q_wr    <= req_write;
      q_cl3   <= cas_lat3;
      q_row   <= a_row;
      q_bank  <= a_bank;
      q_col   <= a_col;
      q_wdata <= req_wdata;
      q_be    <= req_be;
    end
  end

  // sequence
  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:         if (accept) st_nx = ST_ACT;
      ST_ACT, ST_GAP:  st_nx = (age_n >= T_RCD) ? ST_COL : ST_GAP;
      ST_COL, ST_HOLD: st_nx = (age_n >= (q_wr ? P_WR : P_RD)) ? ST_PRE : ST_HOLD;
      ST_PRE, ST_RECOV:
        st_nx = (age_n >= (q_wr ? N_WR : N_RD) - 1) ? ST_IDLE : ST_RECOV;
      default:         st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // pin decode
  always_comb begin
    cmd      = CMD_NOP;
    sd_ba    = '0;
    sd_a     = '0;
    sd_dqm   = '0;
    sd_dq_oe = 1'b0;
    unique case (st)
      ST_ACT: begin
        cmd   = CMD_ACT;
        sd_ba = q_bank;
        sd_a  = q_row;
      end
      ST_COL: begin
        cmd   = q_wr ? CMD_WR : CMD_RD;
        sd_ba = q_bank;
        sd_a[COL_W-1:0] = q_col;
        if (q_wr) begin
          sd_dq_oe = 1'b1;
          sd_dqm   = ~q_be;
        end
      end
      ST_PRE: begin
        cmd          = CMD_PRE;
        sd_ba        = q_bank;
        sd_a[AP_BIT] = 1'b1;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dq_out = q_wdata;

  sdram_seq_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n),
    .issue(cmd == CMD_RD), .cl3(q_cl3),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // ---------------------------------------------------------------
  // spacing monitors for the assertions below
  logic [CHK_W-1:0] since_act, since_col, since_pre, since_rd;
  logic             last_wr, row_open;
  logic [31:0]      open_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_col <= '1;
      since_pre <= '1;
      since_rd  <= '1;
      last_wr   <= 1'b0;
      row_open  <= 1'b0;
      open_cnt  <= '0;
    end else begin
      since_act <= (cmd == CMD_ACT) ? CHK_W'(1) : (since_act == '1 ? since_act : since_act + 1'b1);
      since_pre <= (cmd == CMD_PRE) ? CHK_W'(1) : (since_pre == '1 ? since_pre : since_pre + 1'b1);
      since_rd  <= (cmd == CMD_RD)  ? CHK_W'(1) : (since_rd  == '1 ? since_rd  : since_rd  + 1'b1);
      if (cmd == CMD_RD || cmd == CMD_WR) begin
        since_col <= CHK_W'(1);
        last_wr   <= (cmd == CMD_WR);
      end else if (since_col != '1) begin
        since_col <= since_col + 1'b1;
      end
      if (cmd == CMD_ACT) begin
        row_open <= 1'b1;
        open_cnt <= 32'd1;
      end else if (cmd == CMD_PRE) begin
        row_open <= 1'b0;
        open_cnt <= '0;
      end else if (row_open) begin
        open_cnt <= open_cnt + 1'b1;
      end
    end
  end

  // R4
  col_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act == CHK_W'(T_RCD));

  // R5
  pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (since_act >= CHK_W'(T_RAS)) &&
                         (!last_wr || since_col >= CHK_W'(T_WR)));

  // R5
  row_open_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_cnt < 32'(T_RAS_MAX));

  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> (since_act >= CHK_W'(T_RC)) && (since_pre >= CHK_W'(T_RP)) &&
                         (!last_wr || since_col >= CHK_W'(T_DAL)));

  // R7
  accept_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == CMD_ACT));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |-> !req_ready);

  // R8
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == CMD_WR));

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> since_rd == (q_cl3 ? CHK_W'(4) : CHK_W'(3)));
endmodule

// File: tb/sdram_seq_tb_top.sv
module sdram_seq_tb_top;
  localparam int DW = 32, BW = 4, AW = 23;
  localparam int T_RCD = 2, T_RAS = 5, T_RP = 2, T_RC = 7, T_WR = 2, T_DAL = 5;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_NOP = 4'b0111;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cas_lat3, refresh_busy, req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
  logic [BW-1:0] req_be, sd_dqm;
  logic rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_a;

  sdram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .refresh_busy(refresh_busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] a;
    logic [3:0]  dqm;
    logic        oe;
    logic [31:0] dout;
    int          cl;
    int          addr;
    logic [3:0]  be;
  } exp_t;

  typedef struct {
    logic        wr;
    logic [22:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        cl3;
    int          delay;
  } txn_t;

  txn_t        txq[$];
  exp_t        cq[$];
  logic [31:0] mem[int];
  logic [31:0] drv_dq[int];
  logic [31:0] exp_rd[int];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] pat(input int addr);
    return (32'(addr) * 32'h0000_9E37) ^ 32'hC3C3_0000;
  endfunction

  function automatic exp_t nop_e();
    exp_t e;
    e.cmd = C_NOP; e.ba = '0; e.a = '0; e.dqm = '0; e.oe = 1'b0;
    e.dout = '0; e.cl = 2; e.addr = 0; e.be = '0;
    return e;
  endfunction

  // expected pins for every cycle after an accepted request
  function automatic void push_seq(input txn_t t);
    int p, n;
    p = imax(T_RAS, T_RCD + (t.wr ? T_WR : 1));
    n = t.wr ? imax(imax(p + T_RP, T_RC), T_RCD + T_DAL) : imax(p + T_RP, T_RC);
    for (int g = 0; g <= n - 2; g++) begin
      exp_t e;
      e = nop_e();
      if (g == 0) begin
        e.cmd = C_ACT; e.ba = t.addr[10:9]; e.a = t.addr[22:11];
      end else if (g == T_RCD) begin
        e.cmd = t.wr ? C_WR : C_RD; e.ba = t.addr[10:9];
        e.a = {3'b000, t.addr[8:0]};
        e.cl = t.cl3 ? 3 : 2; e.addr = int'(t.addr); e.be = t.be;
        if (t.wr) begin
          e.oe = 1'b1; e.dout = t.wd; e.dqm = ~t.be;
        end
      end else if (g == p) begin
        e.cmd = C_PRE; e.a = 12'h400;
      end
      cq.push_back(e);
    end
  endfunction

  function automatic void add(input logic wr, input logic [22:0] addr, input logic [31:0] wd,
                              input logic [3:0] be, input logic cl3, input int delay);
    txn_t t;
    t.wr = wr; t.addr = addr; t.wd = wd; t.be = be; t.cl3 = cl3; t.delay = delay;
    txq.push_back(t);
  endfunction

  initial begin
    int cyc;
    int last_rd;
    rst_n = 1'b0; cas_lat3 = 1'b0; refresh_busy = 1'b0; req_valid = 1'b0;
    req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0; sd_dq_in = '0;

    add(1, 23'h000000, 32'h1111_1111, 4'hF, 0, 0);
    add(1, 23'h7FFFFF, 32'hA5A5_A5A5, 4'hF, 0, 0);
    add(1, 23'h123456, 32'hCAFE_BABE, 4'b0101, 0, 3);
    add(0, 23'h123456, '0, 4'hF, 0, 0);
    add(0, 23'h7FFFFF, '0, 4'hF, 1, 0);
    add(0, 23'h000000, '0, 4'hF, 1, 5);
    add(1, 23'h000000, 32'h0000_0000, 4'b1000, 1, 0);
    add(0, 23'h000000, '0, 4'hF, 0, 0);
    add(0, 23'h2AAAAA, '0, 4'hF, 1, 0);
    add(1, 23'h555555, 32'h8765_4321, 4'b0011, 0, 0);
    add(0, 23'h555555, '0, 4'hF, 0, 0);
    add(0, 23'h555555, '0, 4'hF, 1, 0);
    add(0, 23'h600A01, '0, 4'hF, 0, 0);

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "cmd in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk("R1", "rd_valid in reset", rd_valid, 1'b0);
    chk("R1", "dq_oe in reset", sd_dq_oe, 1'b0);
    rst_n = 1'b1;

    cyc = 0;
    last_rd = 0;
    while (!finished) begin
      exp_t e;
      logic exp_rdy;
      @(negedge clk);
      // inputs for this cycle
      refresh_busy = (cyc >= 20 && cyc < 34) || (cyc >= 90 && cyc < 95);
      req_valid = 1'b0;
      if (txq.size() > 0) begin
        if (txq[0].delay > 0) begin
          txq[0].delay--;
        end else begin
          req_valid = 1'b1;
          req_write = txq[0].wr; req_addr = txq[0].addr; req_wdata = txq[0].wd;
          req_be = txq[0].be; cas_lat3 = txq[0].cl3;
        end
      end
      if (!req_valid) begin
        req_addr = 23'(cyc * 7919); req_write = cyc[0]; cas_lat3 = cyc[1];
      end
      sd_dq_in = drv_dq.exists(cyc) ? drv_dq[cyc] : (32'hDEAD_0000 ^ 32'(cyc));
      #1;
      exp_rdy = (cq.size() == 0) && !refresh_busy;
      e = (cq.size() > 0) ? cq.pop_front() : nop_e();

      if (cyc == 0) begin
        chk("R1", "cmd after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk("R1", "ready after reset", req_ready, !refresh_busy);
      end
      chk("R7", "req_ready", req_ready, exp_rdy);
      case (e.cmd)
        C_ACT: chk("R6", "ACTIVE slot", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
        C_RD, C_WR: chk("R4", "column slot", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
        C_PRE: chk("R5", "PRECHARGE slot", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
        default: chk("R3", "NOP slot", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.cmd);
      endcase
      if (e.cmd == C_ACT) begin
        chk("R2", "bank with ACTIVE", sd_ba, e.ba);
        chk("R2", "row on A", sd_a, e.a);
      end
      if (e.cmd == C_RD || e.cmd == C_WR) begin
        chk("R2", "bank with column", sd_ba, e.ba);
        chk("R2", "column on A", sd_a, e.a);
      end
      if (e.cmd == C_PRE) chk("R5", "A10 all-bank", sd_a[10], 1'b1);
      chk("R8", "dq_oe", sd_dq_oe, e.oe);
      chk("R8", "dqm", sd_dqm, e.dqm);
      if (e.oe) chk("R8", "write data", sd_dq_out, e.dout);
      chk("R9", "rd_valid", rd_valid, exp_rd.exists(cyc));
      if (exp_rd.exists(cyc)) chk("R9", "rd_data", rd_data, exp_rd[cyc]);

      // memory model
      if (e.cmd == C_WR) begin
        logic [31:0] v;
        v = mem.exists(e.addr) ? mem[e.addr] : pat(e.addr);
        for (int b = 0; b < BW; b++) if (e.be[b]) v[b*8 +: 8] = e.dout[b*8 +: 8];
        mem[e.addr] = v;
      end
      if (e.cmd == C_RD) begin
        logic [31:0] v;
        v = mem.exists(e.addr) ? mem[e.addr] : pat(e.addr);
        drv_dq[cyc + e.cl] = v;
        exp_rd[cyc + e.cl + 1] = v;
        last_rd = cyc + e.cl + 1;
      end
      if (req_valid && exp_rdy) push_seq(txq.pop_front());

      cyc++;
      if (txq.size() == 0 && cq.size() == 0 && cyc > last_rd + 4) finished = 1;
      if (cyc > 5000) begin
        n_bad++;
        $display("FAIL R7 run did not drain: got %0d pending expected 0", txq.size());
        finished = 1;
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule